// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block sits between a processor data port and a slow RAM, answering word reads and byte-enabled word writes addressed by a 24-bit physical address. Each set holds 2^Z ways and each line holds 2^J words of four bytes. An access that finds its line answers in the same cycle without a stall. Any other access holds the processor in a stall while the controller services the miss. If the chosen victim line has been modified, the controller first copies it back to RAM in one burst. It then fetches the new line in a second burst and releases the stall, so the repeated access hits.

The processor must keep its request and its operands steady while the stall is high. The RAM side carries one burst at a time. The burst address is the line base and stays fixed for the whole burst. Words then move one per acknowledge, starting at the lowest word of the line and going up. Modified data reaches RAM only when a modified line is evicted.

Top module: `wbc_cache`

## Requirements
- R1: The address splits, from the top, into tag, set index, word select and byte offset. The word select sits at bits [J+1:2] and the set index sits just above it. With the defaults (Z=1, J=2, 16 lines) the tag is [23:7], the index is [6:4] and the word is [3:2].
- R2: An access hits only when a way of the indexed set has its valid bit set and holds the address tag. No two ways of one set ever hold the same tag.
- R3: A hit asserts `hit_o` in the cycle of the request, with `stall_o` low. A read hit returns the addressed word on `rd_data_o` in that same cycle.
- R4: An access that misses keeps `stall_o` high until the line is present. The same access then hits and returns the current data.
- R5: A write hit replaces only the bytes whose `be_i` bit is set (bit n covers data bits [8n+7:8n]). It marks the line modified and starts no RAM traffic.
- R6: During a burst, `mem_addr_o` holds the line base with its low J+2 bits at zero. The burst moves exactly 2^J words in ascending order, one per `mem_ack_i`.
- R7: When the victim line is modified, its whole line is written back in one burst. The fill read burst begins only after that write burst ends.
- R8: The victim is the lowest-numbered way of the set whose valid bit is clear. When every way is valid, the victim is the least recently used way, where both hits and fills count as uses.
- R9: Reset clears every valid bit, so the first access to any address after reset misses.
- R10: A filled line is valid and unmodified. Evicting a line that was only read starts no write burst.
- R11: A write that misses first fills the line. The same write then hits, merges its enabled bytes and marks the line modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Processor access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Physical byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables for writes |
| rd_data_o | output | 32 | Read data, valid while `hit_o` is high |
| hit_o | output | 1 | Access completes this cycle |
| stall_o | output | 1 | Access must be held |
| mem_valid_o | output | 1 | Burst in progress |
| mem_we_o | output | 1 | Burst direction, 1 = write to RAM |
| mem_addr_o | output | 24 | Line base address of the burst |
| mem_wdata_o | output | 32 | Current word of a write burst |
| mem_ack_i | input | 1 | RAM accepts or delivers one word |
| mem_rdata_i | input | 32 | Word delivered during a read burst |

## Verification
The hardest case to reach is a least-recently-used victim that is also modified. To get there, the set must be full, the recency order must be known, and the victim must have been written earlier. The bench fills one set with directed accesses, then touches the ways in a chosen order. A later miss must then evict a dirty line. The RAM model checks that the write burst is complete before the read burst begins. A long seeded random run over a small pool of tags keeps these evictions happening, and the data read back is compared against a bench memory image.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } wbc_state_e;
endpackage

// File: rtl/wbc_way_match.sv
module wbc_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 17,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [WAYS-1:0]            valid_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic [WAYS-1:0]            match_o,
    output logic                       any_o,
    output logic [WAY_W-1:0]           way_o
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_o[w] = valid_i[w] && (tags_i[w] == tag_i);
    end

    always_comb begin
        way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_o[w]) way_o = WAY_W'(w);
        end
    end

    assign any_o = |match_o;
endmodule

// File: rtl/wbc_victim_pick.sv
module wbc_victim_pick #(
    parameter int WAYS  = 2,
    parameter int AGE_W = 1,
    parameter int WAY_W = 1
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][AGE_W-1:0] age_i,
    output logic [WAY_W-1:0]           victim_o
);
    always_comb begin
        victim_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_i[w] == AGE_W'(WAYS - 1)) victim_o = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) victim_o = WAY_W'(w);
        end
    end

    // an empty way is always preferred over evicting a live line
    assert_empty_first_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (~valid_i != '0) |-> !valid_i[victim_o]);
endmodule

// File: rtl/wbc_lru_next.sv
module wbc_lru_next #(
    parameter int WAYS  = 2,
    parameter int AGE_W = 1,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age_i,
    input  logic [WAY_W-1:0]           touch_i,
    output logic [WAYS-1:0][AGE_W-1:0] age_o
);
    logic [AGE_W-1:0] pivot;

    always_comb begin
        pivot = age_i[touch_i];
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_i)   age_o[w] = '0;
            else if (age_i[w] < pivot)  age_o[w] = age_i[w] + 1'b1;
            else                        age_o[w] = age_i[w];
        end
    end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache #(
    parameter int Z          = 1,
    parameter int J          = 2,
    parameter int LINES_LOG2 = 4
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        req_i,
    input  logic        we_i,
    input  logic [23:0] addr_i,
    input  logic [31:0] wdata_i,
    input  logic [3:0]  be_i,
    output logic [31:0] rd_data_o,
    output logic        hit_o,
    output logic        stall_o,
    output logic        mem_valid_o,
    output logic        mem_we_o,
    output logic [23:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    input  logic        mem_ack_i,
    input  logic [31:0] mem_rdata_i
);
    import wbc_pkg::*;

    localparam int WAYS     = 1 << Z;
    localparam int WORDS    = 1 << J;
    localparam int SET_BITS = LINES_LOG2 - Z;
    localparam int SETS     = 1 << SET_BITS;
    localparam int OFF_BITS = J + 2;
    localparam int TAG_W    = 24 - SET_BITS - OFF_BITS;
    localparam int AGE_W    = (Z > 0) ? Z : 1;
    localparam int WAY_W    = (Z > 0) ? Z : 1;
    localparam int CNT_W    = (J > 0) ? J : 1;

    typedef struct packed {
        wbc_state_e                                    st;
        logic [WAY_W-1:0]                              vict;
        logic [CNT_W-1:0]                              cnt;
        logic [SET_BITS-1:0]                           mset;
        logic [TAG_W-1:0]                              mtag;
        logic [SETS-1:0][WAYS-1:0]                     valid;
        logic [SETS-1:0][WAYS-1:0]                     dirty;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]          tags;
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]          age;
        logic [SETS-1:0][WAYS-1:0][WORDS-1:0][31:0]    data;
    } regs_t;

    regs_t q, d;

    logic [SET_BITS-1:0]        set_i;
    logic [TAG_W-1:0]           tag_i;
    logic [CNT_W-1:0]           word_i;
    logic [WAYS-1:0]            match_vec;
    logic                       match_any;
    logic [WAY_W-1:0]           hway;
    logic [WAY_W-1:0]           victim;
    logic [WAYS-1:0][AGE_W-1:0] age_new;
    logic                       last_beat;

    assign set_i  = addr_i[OFF_BITS +: SET_BITS];
    assign tag_i  = addr_i[23 -: TAG_W];
    assign word_i = (J > 0) ? addr_i[2 +: CNT_W] : '0;

    wbc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .tags_i (q.tags[set_i]),
        .valid_i(q.valid[set_i]),
        .tag_i  (tag_i),
        .match_o(match_vec),
        .any_o  (match_any),
        .way_o  (hway)
    );

    wbc_victim_pick #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_victim (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_i (q.valid[set_i]),
        .age_i   (q.age[set_i]),
        .victim_o(victim)
    );

    wbc_lru_next #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_lru (
        .age_i  (q.age[set_i]),
        .touch_i(hway),
        .age_o  (age_new)
    );

    assign hit_o       = req_i && (q.st == ST_IDLE) && match_any;
    assign stall_o     = req_i && !hit_o;
    assign rd_data_o   = q.data[set_i][hway][word_i];
    assign last_beat   = mem_ack_i && (q.cnt == CNT_W'(WORDS - 1));
    assign mem_valid_o = (q.st != ST_IDLE);
    assign mem_we_o    = (q.st == ST_WBACK);
    assign mem_addr_o  = (q.st == ST_WBACK)
                       ? {q.tags[q.mset][q.vict], q.mset, {OFF_BITS{1'b0}}}
                       : {q.mtag, q.mset, {OFF_BITS{1'b0}}};
    assign mem_wdata_o = q.data[q.mset][q.vict][q.cnt];

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (hit_o) begin
                    d.age[set_i] = age_new;
                    if (we_i) begin
                        for (int b = 0; b < 4; b++) begin
                            if (be_i[b]) d.data[set_i][hway][word_i][8*b +: 8] = wdata_i[8*b +: 8];
                        end
                        d.dirty[set_i][hway] = 1'b1;
                    end
                end else if (req_i) begin
                    d.vict = victim;
                    d.mset = set_i;
                    d.mtag = tag_i;
                    d.cnt  = '0;
                    d.st   = (q.valid[set_i][victim] && q.dirty[set_i][victim]) ? ST_WBACK : ST_FILL;
                end
            end
            ST_WBACK: begin
                if (mem_ack_i) begin
                    d.cnt = q.cnt + 1'b1;
                    if (last_beat) begin
                        d.cnt = '0;
                        d.st  = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack_i) begin
                    d.data[q.mset][q.vict][q.cnt] = mem_rdata_i;
                    d.cnt = q.cnt + 1'b1;
                    if (last_beat) begin
                        d.cnt                  = '0;
                        d.valid[q.mset][q.vict] = 1'b1;
                        d.dirty[q.mset][q.vict] = 1'b0;
                        d.tags[q.mset][q.vict]  = q.mtag;
                        d.st                   = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    q.age[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            q <= d;
        end
    end

    assert_single_copy_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(match_vec));

    assert_write_marks_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (hit_o && we_i) |=> q.dirty[$past(set_i)][$past(hway)]);

    assert_burst_steady_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_valid_o && !mem_ack_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    assert_fill_follows_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_valid_o && mem_we_o && last_beat) |=> (mem_valid_o && !mem_we_o));

    assert_empty_after_reset_R9: assert property (@(posedge clk_i)
        $past(rst_i) |-> (q.valid == '0));

    assert_fresh_clean_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.st == ST_FILL && last_beat) |=>
        (q.valid[$past(q.mset)][$past(q.vict)] && !q.dirty[$past(q.mset)][$past(q.vict)]));
endmodule

// File: tb/wbc_cache_bench.sv
module wbc_cache_bench;
    localparam int WORDS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, we = 1'b0;
    logic [23:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rd_data;
    logic        hit, stall;
    logic        mem_valid, mem_we, mem_ack = 1'b0;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    int wr_bursts = 0;
    bit [31:0] ram  [int];
    bit [31:0] refm [int];

    always #2 clk = ~clk;

    wbc_cache u_wbc_cache (
        .clk_i(clk), .rst_i(rst), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .be_i(be), .rd_data_o(rd_data), .hit_o(hit), .stall_o(stall),
        .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
    );

    function automatic bit [31:0] init_word(input int a);
        return (a * 32'h9E3779B1) ^ 32'h5A3C_0F11;
    endfunction

    function automatic bit [31:0] ram_get(input int a);
        return ram.exists(a) ? ram[a] : init_word(a);
    endfunction

    function automatic bit [31:0] ref_get(input int a);
        return refm.exists(a) ? refm[a] : init_word(a);
    endfunction

    function automatic bit [31:0] merge(input bit [31:0] old, input bit [31:0] nw, input bit [3:0] m);
        bit [31:0] r = old;
        for (int b = 0; b < 4; b++) if (m[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    task automatic check(input string req_tag, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // RAM model: a short wait, then one word per cycle
    initial begin
        bit        inb = 0;
        int        wt = 0, beat = 0;
        bit        kind = 0;
        bit        need_fill = 0;
        bit [23:0] base = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst) begin
                inb = 0; need_fill = 0;
            end else if (mem_valid && !inb) begin
                inb = 1; wt = 0; beat = 0; base = mem_addr; kind = mem_we;
                if (kind) wr_bursts++;
                check("R6 line base aligned", base[3:0] == 4'h0, base, {base[23:4], 4'h0});
                if (need_fill) begin
                    check("R7 fill follows write-back", !kind, kind, 0);
                    need_fill = 0;
                end
            end else if (inb) begin
                check("R6 address held in burst", mem_addr == base && mem_we == kind, mem_addr, base);
                if (wt < 2) wt++;
                else begin
                    mem_ack = 1'b1;
                    if (kind) ram[int'(base) + 4*beat] = mem_wdata;
                    else      mem_rdata = ram_get(int'(base) + 4*beat);
                    beat++;
                    if (beat == WORDS) begin
                        inb = 0;
                        if (kind) need_fill = 1;
                    end
                end
            end
        end
    end

    task automatic access(input bit w, input bit [23:0] a, input bit [31:0] d,
                          input bit [3:0] m, output bit [31:0] rd, output int stalls);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; be = m;
        stalls = 0;
        #1;
        while (!hit && stalls < 100) begin
            @(negedge clk);
            stalls++;
            #1;
        end
        rd = rd_data;
        @(posedge clk);
        #1 req = 1'b0;
        if (w) refm[int'(a)] = merge(ref_get(int'(a)), d, m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        bit [31:0] rd;
        int st, wb0;
        bit [23:0] ta, tb_, tc, td;
        ta = 24'h0000A0; tb_ = 24'h000120; tc = 24'h0001A0; td = 24'h000220;
        process::self().srandom(32'd7321);

        repeat (3) @(posedge clk);
        #1;
        check("R9 reset idle outputs", !stall && !hit && !mem_valid, {stall, hit, mem_valid}, 0);
        @(negedge clk) rst = 1'b0;

        // R9/R4 cold read misses, then returns RAM data
        access(0, ta, 0, 0, rd, st);
        check("R9 first access misses", st > 0, st, 1);
        check("R4 miss data", rd == init_word(int'(ta)), rd, init_word(int'(ta)));
        // R3/R1 same line other word hits at once
        access(0, ta + 4, 0, 0, rd, st);
        check("R3 hit without stall", st == 0, st, 0);
        check("R1 word select", rd == init_word(int'(ta) + 4), rd, init_word(int'(ta) + 4));
        // R5 partial write hit
        wb0 = wr_bursts;
        access(1, ta + 8, 32'hDEAD_BEEF, 4'b0101, rd, st);
        check("R5 write hit no stall", st == 0, st, 0);
        access(0, ta + 8, 0, 0, rd, st);
        check("R5 byte merge", rd == ref_get(int'(ta) + 8), rd, ref_get(int'(ta) + 8));
        check("R5 no RAM traffic", wr_bursts == wb0, wr_bursts, wb0);
        // R8 fill order and LRU
        access(0, tb_, 0, 0, rd, st);
        check("R8 second line misses", st > 0, st, 1);
        access(0, ta, 0, 0, rd, st);
        check("R8 first line kept in other way", st == 0, st, 0);
        wb0 = wr_bursts;
        access(0, tc, 0, 0, rd, st);              // evicts clean B
        check("R10 clean eviction no write", wr_bursts == wb0, wr_bursts, wb0);
        access(0, ta, 0, 0, rd, st);
        check("R8 recently used line kept", st == 0, st, 0);
        access(0, tb_, 0, 0, rd, st);             // evicts C (LRU)
        check("R8 evicted LRU misses", st > 0, st, 1);
        access(0, tb_ + 4, 0, 0, rd, st);         // touch B, A is now LRU
        wb0 = wr_bursts;
        access(0, tc, 0, 0, rd, st);              // evicts dirty A
        check("R7 dirty victim written back", wr_bursts == wb0 + 1, wr_bursts, wb0 + 1);
        check("R7 RAM holds merged word", ram_get(int'(ta) + 8) == ref_get(int'(ta) + 8),
              ram_get(int'(ta) + 8), ref_get(int'(ta) + 8));
        access(0, ta + 8, 0, 0, rd, st);
        check("R4 refetched dirty data", rd == ref_get(int'(ta) + 8), rd, ref_get(int'(ta) + 8));
        // R11 write miss
        access(1, td + 12, 32'h1234_5678, 4'b1110, rd, st);
        check("R11 write miss stalls", st > 0, st, 1);
        access(0, td + 12, 0, 0, rd, st);
        check("R11 merged after fill", rd == ref_get(int'(td) + 12), rd, ref_get(int'(td) + 12));

        // seeded random mix over a small tag pool
        for (int i = 0; i < 3000; i++) begin
            bit [23:0] a;
            bit        w;
            bit [31:0] d;
            bit [3:0]  m;
            a = {14'd0, 3'($urandom_range(1, 6)), 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 2'b00};
            w = ($urandom_range(0, 2) == 0);
            d = $urandom;
            m = 4'($urandom);
            access(w, a, d, m, rd, st);
            if (!w) check("R4 random read data", rd == ref_get(int'(a)), rd, ref_get(int'(a)));
            else    check("R11 random write completes", st < 100, st, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule